// File: doc/BRIEF.md
# Prioritized Fault Status Capture

This block records translation faults into two registers: a status word that describes the most important fault still waiting to be read, and an address register that holds that fault's virtual address. Every fault report names a class: instruction access, data access or translation table access. The class of the fault already held decides whether a new report may replace it. Translation table faults rank highest and instruction faults rank lowest. An overwrite flag shows whether a fault of the same class was lost.

Software reads the registers through a select line, and the selected register is always visible on the read data. A read strobe on the status register clears the held class, the fault type and the overwrite flag, so the next fault of any class is captured. The register write port exists only so the register space is complete: a write to either register has no effect.

Top module: `fault_capture_top`

## Requirements
- R1: While reset is high at a clock edge, the status word, the held class and the address register all become zero.
- R2: The status word carries bus error bits in 17:10, level in 9:8, access type in 7:5, fault type in 4:2, address-valid in bit 1 and overwrite in bit 0. All other bits read as zero. The level value (0 for the context table, 1 to 3 for a page table level) is stored exactly as reported.
- R3: When nothing is held, a fault with class code 1 (instruction), 2 (data) or 3 (table) is captured. Its fields and address are stored, address-valid becomes 1 and overwrite becomes 0.
- R4: An instruction fault arriving over an unread instruction fault replaces the status and the address and sets overwrite.
- R5: An instruction fault does not replace a held data fault. Neither an instruction fault nor a data fault replaces a held table fault. In these cases the status and the address stay unchanged.
- R6: A data fault replacing an instruction fault leaves overwrite at 0. A table fault replacing an instruction or data fault also leaves overwrite at 0.
- R7: A data or table fault arriving over an unread fault of the same class replaces it and sets overwrite.
- R8: A read strobe with select 0 (status) clears the held class, the fault type and overwrite. Level, access type, bus error bits, address-valid and the address are kept, and any class may be captured next.
- R9: When a fault and a status read occur in the same cycle, the read data in that cycle shows the old status. The new fault is then captured as if nothing were held, with overwrite 0.
- R10: Register writes, with select 0 or select 1, change neither the status word nor the address register.
- R11: A fault strobe with class code 0 is ignored.
- R12: A read strobe with select 1 (address) changes neither the status word nor the address register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_valid | input | 1 | Fault report strobe |
| flt_class | input | 2 | Fault class: 0 none, 1 instruction, 2 data, 3 table |
| flt_level | input | 2 | Table level of the faulting entry |
| flt_acc_type | input | 3 | Access type of the faulting access |
| flt_type | input | 3 | Fault type code |
| flt_bus_err | input | 8 | External bus error bits |
| flt_vaddr | input | ADDR_W | Virtual address of the fault |
| rd_en | input | 1 | Read strobe, takes effect at the clock edge |
| rd_sel | input | 1 | Register select: 0 status, 1 address |
| rd_data | output | DATA_W | Selected register contents |
| wr_en | input | 1 | Write strobe (ignored) |
| wr_sel | input | 1 | Write register select (ignored) |
| wr_data | input | DATA_W | Write data (ignored) |

## Verification
On every cycle the assertions check the class rules. A lower-ranked fault never disturbs a held table fault. A same-class replacement always sets overwrite and a promotion always clears it. A read strobe alone always clears class, fault type and overwrite. The address register changes only on an accepted fault. The bench scenarios are what show the exact packing of the status bits, the combination of old read data and clean capture in one cycle, and the absence of any effect from writes and address reads. Those follow only from concrete values observed at the read port.

// File: rtl/fault_cap_pkg.sv
`timescale 1ns/1ps
package fault_cap_pkg;

    localparam int EBE_W  = 8;
    localparam int LVL_W  = 2;
    localparam int ACC_W  = 3;
    localparam int FT_W   = 3;
    // Status word: ebe | level | access | ftype | fav | ow  (R2)
    localparam int STAT_W = EBE_W + LVL_W + ACC_W + FT_W + 2;

    // Numeric order is the replacement priority
    typedef enum logic [1:0] {
        FC_NONE  = 2'd0,
        FC_INSN  = 2'd1,
        FC_DATA  = 2'd2,
        FC_TABLE = 2'd3
    } fclass_e;

    typedef struct packed {
        logic [EBE_W-1:0] ebe;
        logic [LVL_W-1:0] lvl;
        logic [ACC_W-1:0] acc;
        logic [FT_W-1:0]  ftype;
    } fault_info_t;

    function automatic logic [STAT_W-1:0] pack_status(fault_info_t info,
                                                      logic fav, logic ow);
        return {info.ebe, info.lvl, info.acc, info.ftype, fav, ow};
    endfunction

endpackage

// File: rtl/fault_cap_arbiter.sv
`timescale 1ns/1ps
module fault_cap_arbiter
    import fault_cap_pkg::*;
(
    input  logic    flt_valid,
    input  fclass_e new_cls,
    input  fclass_e held_cls,
    input  logic    clear,
    output logic    accept,
    output logic    ow_next
);
    fclass_e eff_held;

    always_comb begin
        // a status read in the same cycle empties the register first (R9)
        eff_held = clear ? FC_NONE : held_cls;
        accept   = flt_valid && (new_cls != FC_NONE) &&
                   ((eff_held == FC_NONE) || (new_cls >= eff_held));
        ow_next  = (eff_held == new_cls);
    end

endmodule

// File: rtl/fault_cap_status_reg.sv
`timescale 1ns/1ps
module fault_cap_status_reg
    import fault_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              ow_next,
    input  fclass_e           new_cls,
    input  fault_info_t       info_in,
    input  logic              clear,
    input  logic              fav,
    output fclass_e           held_cls,
    output logic [STAT_W-1:0] status_word
);
    fault_info_t info_q;
    logic        ow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_cls <= FC_NONE;
            info_q   <= '0;
            ow_q     <= 1'b0;
        end else if (accept) begin
            held_cls <= new_cls;
            info_q   <= info_in;
            ow_q     <= ow_next;
        end else if (clear) begin
            held_cls     <= FC_NONE;
            info_q.ftype <= '0;
            ow_q         <= 1'b0;
        end
    end

    assign status_word = pack_status(info_q, fav, ow_q);

    assert_capture_fields_R3: assert property (@(posedge clk) disable iff (rst)
        accept |=> (held_cls == $past(new_cls)) && (info_q == $past(info_in)));

    // R4 and R7: same class over an unread fault sets overwrite
    assert_ow_repeat_R7: assert property (@(posedge clk) disable iff (rst)
        (accept && !clear && held_cls == new_cls) |=> ow_q);

    assert_ow_promote_R6: assert property (@(posedge clk) disable iff (rst)
        (accept && !clear && held_cls != FC_NONE && held_cls != new_cls) |=> !ow_q);

    assert_read_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (clear && !accept) |=> (held_cls == FC_NONE) && !ow_q && (info_q.ftype == '0));

endmodule

// File: rtl/fault_cap_addr_reg.sv
`timescale 1ns/1ps
module fault_cap_addr_reg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] vaddr_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic              addr_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q     <= '0;
            addr_valid <= 1'b0;
        end else if (accept) begin
            addr_q     <= vaddr_in;
            addr_valid <= 1'b1;
        end
    end

    // only a captured fault moves the address (R5, R10, R12)
    assert_addr_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(addr_q));

    assert_addr_valid_R3: assert property (@(posedge clk) disable iff (rst)
        accept |=> addr_valid && (addr_q == $past(vaddr_in)));

endmodule

// File: rtl/fault_capture_top.sv
`timescale 1ns/1ps
module fault_capture_top
    import fault_cap_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flt_valid,
    input  logic [1:0]        flt_class,
    input  logic [LVL_W-1:0]  flt_level,
    input  logic [ACC_W-1:0]  flt_acc_type,
    input  logic [FT_W-1:0]   flt_type,
    input  logic [EBE_W-1:0]  flt_bus_err,
    input  logic [ADDR_W-1:0] flt_vaddr,
    input  logic              rd_en,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data
);
    localparam logic SEL_STATUS = 1'b0;

    fclass_e           new_cls;
    fclass_e           held_cls;
    fault_info_t       info_in;
    logic              clear;
    logic              accept;
    logic              ow_next;
    logic              addr_valid;
    logic [ADDR_W-1:0] addr_q;
    logic [STAT_W-1:0] status_word;
    logic              wr_ignored_unused;

    assign new_cls = fclass_e'(flt_class);
    assign info_in = '{ebe: flt_bus_err, lvl: flt_level, acc: flt_acc_type, ftype: flt_type};
    assign clear   = rd_en && (rd_sel == SEL_STATUS);
    assign wr_ignored_unused = ^{wr_en, wr_sel, wr_data};

    fault_cap_arbiter arb_i (
        .flt_valid (flt_valid),
        .new_cls   (new_cls),
        .held_cls  (held_cls),
        .clear     (clear),
        .accept    (accept),
        .ow_next   (ow_next)
    );

    fault_cap_status_reg stat_i (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .ow_next     (ow_next),
        .new_cls     (new_cls),
        .info_in     (info_in),
        .clear       (clear),
        .fav         (addr_valid),
        .held_cls    (held_cls),
        .status_word (status_word)
    );

    fault_cap_addr_reg #(.ADDR_W(ADDR_W)) addr_i (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .vaddr_in   (flt_vaddr),
        .addr_q     (addr_q),
        .addr_valid (addr_valid)
    );

    always_comb begin
        rd_data = '0;
        if (rd_sel == SEL_STATUS) rd_data[STAT_W-1:0] = status_word;
        else                      rd_data[ADDR_W-1:0] = addr_q;
    end

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (status_word == '0) && (addr_q == '0) && (held_cls == FC_NONE));

    assert_table_kept_R5: assert property (@(posedge clk) disable iff (rst)
        (flt_valid && held_cls == FC_TABLE && new_cls != FC_TABLE && !clear)
        |=> $stable(status_word) && $stable(addr_q));

    assert_null_class_R11: assert property (@(posedge clk) disable iff (rst)
        (flt_valid && new_cls == FC_NONE && !rd_en) |=> $stable(status_word));

endmodule

// File: tb/fault_capture_top_tb_top.sv
`timescale 1ns/1ps
module fault_capture_top_tb_top;

    typedef struct packed {
        logic        v;
        logic [1:0]  cls;
        logic [1:0]  lvl;
        logic [2:0]  at;
        logic [2:0]  ft;
        logic [7:0]  ebe;
        logic [31:0] va;
        logic        rd;
        logic [31:0] es;
        logic [31:0] ea;
    } vec_t;

    // class 1 instruction, 2 data, 3 table; rd = status read strobe
    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 2'd1, 2'd1, 3'd2, 3'd1, 8'h00, 32'h1000, 1'b0, 32'h00146,  32'h1000}, // R3
        '{1'b1, 2'd1, 2'd2, 3'd3, 3'd2, 8'h05, 32'h2000, 1'b0, 32'h0166B,  32'h2000}, // R4
        '{1'b1, 2'd2, 2'd3, 3'd1, 3'd3, 8'h11, 32'h3000, 1'b0, 32'h0472E,  32'h3000}, // R6
        '{1'b1, 2'd1, 2'd0, 3'd0, 3'd4, 8'hFF, 32'h4000, 1'b0, 32'h0472E,  32'h3000}, // R5
        '{1'b1, 2'd2, 2'd1, 3'd4, 3'd5, 8'h22, 32'h5000, 1'b0, 32'h08997,  32'h5000}, // R7
        '{1'b1, 2'd3, 2'd2, 3'd5, 3'd6, 8'h80, 32'h6000, 1'b0, 32'h202BA,  32'h6000}, // R6
        '{1'b1, 2'd2, 2'd3, 3'd6, 3'd7, 8'h01, 32'h7000, 1'b0, 32'h202BA,  32'h6000}, // R5
        '{1'b1, 2'd1, 2'd1, 3'd1, 3'd1, 8'h02, 32'h8000, 1'b0, 32'h202BA,  32'h6000}, // R5
        '{1'b1, 2'd3, 2'd0, 3'd7, 3'd1, 8'h40, 32'h9000, 1'b0, 32'h100E7,  32'h9000}, // R7 R2
        '{1'b1, 2'd0, 2'd3, 3'd3, 3'd3, 8'h33, 32'hA000, 1'b0, 32'h100E7,  32'h9000}, // R11
        '{1'b0, 2'd0, 2'd0, 3'd0, 3'd0, 8'h00, 32'h0000, 1'b1, 32'h100E2,  32'h9000}, // R8
        '{1'b1, 2'd1, 2'd2, 3'd2, 3'd2, 8'h03, 32'hB000, 1'b0, 32'h00E4A,  32'hB000}  // R8
    };
    localparam string VEC_REQ [NVEC] = '{"R3", "R4", "R6", "R5", "R7", "R6",
                                         "R5", "R5", "R7", "R11", "R8", "R8"};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flt_valid = 1'b0;
    logic [1:0]  flt_class = '0;
    logic [1:0]  flt_level = '0;
    logic [2:0]  flt_acc_type = '0;
    logic [2:0]  flt_type = '0;
    logic [7:0]  flt_bus_err = '0;
    logic [31:0] flt_vaddr = '0;
    logic        rd_en = 1'b0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    fault_capture_top dut_i (
        .clk(clk), .rst(rst), .flt_valid(flt_valid), .flt_class(flt_class),
        .flt_level(flt_level), .flt_acc_type(flt_acc_type), .flt_type(flt_type),
        .flt_bus_err(flt_bus_err), .flt_vaddr(flt_vaddr), .rd_en(rd_en),
        .rd_sel(rd_sel), .rd_data(rd_data), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // observe both registers without a read strobe
    task automatic peek(string req, logic [31:0] es, logic [31:0] ea);
        rd_sel = 1'b0;
        #0.5;
        chk(req, "status", rd_data, es);
        rd_sel = 1'b1;
        #0.5;
        chk(req, "address", rd_data, ea);
        rd_sel = 1'b0;
    endtask

    task automatic drive_fault(logic v, logic [1:0] c, logic [1:0] l, logic [2:0] a,
                               logic [2:0] f, logic [7:0] e, logic [31:0] va);
        flt_valid = v; flt_class = c; flt_level = l;
        flt_acc_type = a; flt_type = f; flt_bus_err = e; flt_vaddr = va;
    endtask

    task automatic idle_inputs();
        drive_fault(1'b0, 2'd0, 2'd0, 3'd0, 3'd0, 8'h00, 32'h0);
        rd_en = 1'b0; rd_sel = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #800000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        peek("R1", 32'h0, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            drive_fault(VECS[i].v, VECS[i].cls, VECS[i].lvl, VECS[i].at,
                        VECS[i].ft, VECS[i].ebe, VECS[i].va);
            rd_en  = VECS[i].rd;
            rd_sel = 1'b0;
            @(posedge clk);
            #1;
            idle_inputs();
            peek(VEC_REQ[i], VECS[i].es, VECS[i].ea);
        end

        // R9: data fault together with a status read; old value visible
        @(negedge clk);
        drive_fault(1'b1, 2'd2, 2'd1, 3'd1, 3'd3, 8'h00, 32'hC000);
        rd_en = 1'b1; rd_sel = 1'b0;
        #0.5;
        chk("R9", "read data same cycle", rd_data, 32'h00E4A);
        @(posedge clk);
        #1;
        idle_inputs();
        peek("R9", 32'h0012E, 32'hC000);

        // R9: instruction fault over a held data fault, with read: captured
        @(negedge clk);
        drive_fault(1'b1, 2'd1, 2'd0, 3'd0, 3'd1, 8'h00, 32'hD000);
        rd_en = 1'b1; rd_sel = 1'b0;
        @(posedge clk);
        #1;
        idle_inputs();
        peek("R9", 32'h00006, 32'hD000);

        // R10: writes to both registers
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'hFFFF_FFFF;
        @(posedge clk);
        #1;
        wr_sel = 1'b1; wr_data = 32'h1234_5678;
        @(posedge clk);
        #1;
        idle_inputs();
        peek("R10", 32'h00006, 32'hD000);

        // R12: read strobe on the address register
        @(negedge clk);
        rd_en = 1'b1; rd_sel = 1'b1;
        @(posedge clk);
        #1;
        idle_inputs();
        peek("R12", 32'h00006, 32'hD000);

        // R4 after R12: instruction fault still counts as an overwrite
        @(negedge clk);
        drive_fault(1'b1, 2'd1, 2'd0, 3'd0, 3'd2, 8'h00, 32'hE000);
        @(posedge clk);
        #1;
        idle_inputs();
        peek("R4", 32'h0000B, 32'hE000);

        // R1: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        peek("R1", 32'h0, 32'h0);

        finish_run();
    end

endmodule